// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Edge Capture

This block is a memory-mapped general-purpose I/O controller in which every pin owns one 32-bit word. That word carries the pin's configuration: direction, driven value, blink and debounce. It also carries the pin's condition: the synchronised input level and two sticky edge flags, one for rising and one for falling edges. Software configures a pin, reads it and acknowledges its edges through that single word. Writing back a value just read clears every flag that was set in it.

Pins are grouped into contiguous ranges of `GROUP_SIZE` pins. A group status bit latches whenever any pin in its range holds an edge flag. Per-group enable bits select which pending groups raise the single interrupt output. A read-only word reports how many pins are implemented. Inputs pass through a two-flop synchroniser and an optional per-pin debounce filter. Outputs can blink at a divided rate, gated by the pin's output value.

Top module: `gpio_pinword_ctrl`

## Requirements
- R1: Pin n's word sits at byte address 0x1000 + 4n. Its bits are: 0 = conditioned input level (read-only), 1 = debounce enable, 2 = tri-state (1 = input), 3 = output value, 4 = blink enable, 5 = rising-edge enable, 6 = rising flag, 7 = falling-edge enable, 8 = falling flag. Bits 31..9 read 0. Read data and `rd_valid` appear on the clock edge after the request.
- R2: Reset is asynchronous and active low, and it takes effect two clock edges after `rst_n` rises. Reset clears all control bits, flags, group status and group enables, and sets every tri-state bit to 1, so `pin_oe` = 0 and `irq` = 0.
- R3: The word at byte address 0x8 returns `NUM_PINS` in bits 15..0 and 0 above. Writes to it have no effect.
- R4: With debounce off, a level on `pin_in` reaches bit 0 on the third rising edge after it is applied, through two synchroniser flops.
- R5: With debounce on, bit 0 takes the synchronised value only on the `DEB_CYCLES`-th consecutive edge at which that value differs from bit 0. A shorter excursion leaves bit 0 unchanged.
- R6: A 0-to-1 change of bit 0 sets the rising flag, and a 1-to-0 change sets the falling flag. This happens only if the matching enable is 1 and the tri-state bit is 1, using the values held before any write on that same edge. Flags stay set until cleared.
- R7: Writing 1 to bit 6 or bit 8 clears that flag, and writing 0 leaves it unchanged. An edge arriving on the same clock as the clearing write leaves the flag set.
- R8: `pin_oe[n]` is the inverse of tri-state. With blink off, `pin_out[n]` equals the output bit. With blink on, it is the output bit ANDed with a blink phase that starts at 0 after reset and toggles every `BLINK_HALF` clocks.
- R9: Group g covers pins g*`GROUP_SIZE` up to the next multiple minus one, capped at `NUM_PINS`-1. The group status word at byte address 0x0 sets bit g on the edge after any pin in the group holds a flag. Writing 1 to a bit clears it, but the bit sets again while a flag in the group is still set.
- R10: The group enable word at byte address 0x4 is read/write, with one bit per group. `irq` is the OR of the enabled status bits and follows a status or enable change on the same edge.
- R11: Writes to unaligned addresses, to pin words at or beyond `NUM_PINS`, or to unmapped addresses change no state. Reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 32 | Read data (0 when not valid) |
| pin_in | input | NUM_PINS | Raw pin inputs |
| pin_out | output | NUM_PINS | Driven pin values |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq | output | 1 | Interrupt line |

## Verification
Results arrive at fixed latencies:

- A pin change reaches the level bit and its edge flag on the third rising edge. The group status follows one edge later, and `irq` follows on that same edge because it is a combinational function of registers.
- Register writes and read data land on the first edge after the request.

The bench keeps a behavioural model that steps at every rising edge, including the two-edge reset release. It compares every output at the falling edge in between, so each result is checked in the exact cycle it is due. Directed reads after each scenario check literal expected values: the reset word, the pin count, flags after edges, clears, debounce excursions and the same-cycle edge-and-clear race.

// File: rtl/gpio_pw_pkg.sv
package gpio_pw_pkg;
  localparam int ADDR_W = 13;

  localparam logic [ADDR_W-1:0] GRP_STAT_ADDR = 13'h000;
  localparam logic [ADDR_W-1:0] GRP_EN_ADDR   = 13'h004;
  localparam logic [ADDR_W-1:0] PIN_CNT_ADDR  = 13'h008;

  // Per-pin configuration and flags; packed order maps onto word bits 8..1.
  typedef struct packed {
    logic fall_flag;
    logic fall_en;
    logic rise_flag;
    logic rise_en;
    logic blink;
    logic out_val;
    logic tristate;
    logic deb_en;
  } pin_cfg_t;

  localparam pin_cfg_t PIN_CFG_RESET = '{tristate: 1'b1, default: 1'b0};
endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic deb_en_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CNT_W = $clog2(DEB_CYCLES + 1);

  logic             sync1_q, sync2_q;
  logic             lvl_q, lvl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (!deb_en_i) begin
      lvl_d = sync2_q;
    end else if (sync2_q != lvl_q) begin
      if (cnt_q == CNT_W'(DEB_CYCLES - 1)) begin
        lvl_d = sync2_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      lvl_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      lvl_q   <= lvl_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = lvl_q;
  assign rise_o  = lvl_d & ~lvl_q;
  assign fall_o  = ~lvl_d & lvl_q;

  AST_DEB_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    ($past(deb_en_i) && (lvl_q != $past(lvl_q))) |-> ($past(cnt_q) == CNT_W'(DEB_CYCLES - 1))); // R5
endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int BLINK_HALF = 8
) (
  input  logic clk,
  input  logic rst_ni,
  output logic phase_o
);
  localparam int CW = $clog2(BLINK_HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(BLINK_HALF - 1));

  always_comb begin
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ni,
  input  logic        we_i,
  input  pin_cfg_t    wcfg_i,
  input  logic        level_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        blink_phase_i,
  output logic [31:0] word_o,
  output logic        deb_en_o,
  output logic        flag_o,
  output logic        pin_out_o,
  output logic        pin_oe_o
);
  pin_cfg_t cfg_q, cfg_d;
  logic     rise_hit, fall_hit;

  assign rise_hit = rise_i & cfg_q.rise_en & cfg_q.tristate;
  assign fall_hit = fall_i & cfg_q.fall_en & cfg_q.tristate;

  always_comb begin
    cfg_d = cfg_q;
    if (we_i) begin
      cfg_d.deb_en   = wcfg_i.deb_en;
      cfg_d.tristate = wcfg_i.tristate;
      cfg_d.out_val  = wcfg_i.out_val;
      cfg_d.blink    = wcfg_i.blink;
      cfg_d.rise_en  = wcfg_i.rise_en;
      cfg_d.fall_en  = wcfg_i.fall_en;
    end
    cfg_d.rise_flag = (cfg_q.rise_flag & ~(we_i & wcfg_i.rise_flag)) | rise_hit;
    cfg_d.fall_flag = (cfg_q.fall_flag & ~(we_i & wcfg_i.fall_flag)) | fall_hit;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= PIN_CFG_RESET;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign word_o    = {23'b0, cfg_q, level_i};
  assign deb_en_o  = cfg_q.deb_en;
  assign flag_o    = cfg_q.rise_flag | cfg_q.fall_flag;
  assign pin_oe_o  = ~cfg_q.tristate;
  assign pin_out_o = cfg_q.out_val & (~cfg_q.blink | blink_phase_i);

  AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cfg_q.rise_flag) |-> $past(cfg_q.rise_en && cfg_q.tristate)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(cfg_q.rise_flag) |-> $past(we_i && wcfg_i.rise_flag)); // R7
endmodule

// File: rtl/gpio_pinword_ctrl.sv
module gpio_pinword_ctrl
  import gpio_pw_pkg::*;
#(
  parameter int NUM_PINS   = 8,
  parameter int GROUP_SIZE = 3,
  parameter int DEB_CYCLES = 16,
  parameter int BLINK_HALF = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE;
  localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  function automatic logic [NUM_PINS-1:0] group_mask(input int g);
    logic [NUM_PINS-1:0] m;
    for (int p = 0; p < NUM_PINS; p++) m[p] = ((p / GROUP_SIZE) == g);
    return m;
  endfunction

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // Address decode
  logic             wr, rd, pin_hit, stat_wr, en_wr;
  logic [IDX_W-1:0] pin_idx;
  logic             unused_wdata;

  assign wr      = req_valid & req_write;
  assign rd      = req_valid & ~req_write;
  assign pin_hit = req_addr[12] && (req_addr[1:0] == 2'b00) &&
                   ({1'b0, req_addr[11:2]} < 11'(NUM_PINS));
  assign pin_idx = req_addr[2 +: IDX_W];
  assign stat_wr = wr && (req_addr == GRP_STAT_ADDR);
  assign en_wr   = wr && (req_addr == GRP_EN_ADDR);
  assign unused_wdata = ^req_wdata;

  // Blink phase shared by all pins
  logic blink_phase;
  gpio_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk    (clk),
    .rst_ni (rst_i),
    .phase_o(blink_phase)
  );

  // Pin slices
  logic [31:0]         pin_word [NUM_PINS];
  logic [NUM_PINS-1:0] pin_flag;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic lvl, rise, fall, deb_en, we;
    assign we = wr && pin_hit && (pin_idx == IDX_W'(p));

    gpio_in_cond #(.DEB_CYCLES(DEB_CYCLES)) u_cond (
      .clk     (clk),
      .rst_ni  (rst_i),
      .pin_i   (pin_in[p]),
      .deb_en_i(deb_en),
      .level_o (lvl),
      .rise_o  (rise),
      .fall_o  (fall)
    );

    gpio_pin_cell u_cell (
      .clk          (clk),
      .rst_ni       (rst_i),
      .we_i         (we),
      .wcfg_i       (pin_cfg_t'(req_wdata[8:1])),
      .level_i      (lvl),
      .rise_i       (rise),
      .fall_i       (fall),
      .blink_phase_i(blink_phase),
      .word_o       (pin_word[p]),
      .deb_en_o     (deb_en),
      .flag_o       (pin_flag[p]),
      .pin_out_o    (pin_out[p]),
      .pin_oe_o     (pin_oe[p])
    );
  end

  // Group summary
  logic [NUM_GROUPS-1:0] grp_any, gstat_q, gstat_d, gen_q, gen_d;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_any[g] = |(pin_flag & group_mask(g));
  end

  always_comb begin
    gstat_d = (gstat_q & ~(stat_wr ? req_wdata[NUM_GROUPS-1:0] : '0)) | grp_any;
    gen_d   = en_wr ? req_wdata[NUM_GROUPS-1:0] : gen_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      gstat_q <= '0;
      gen_q   <= '0;
    end else begin
      gstat_q <= gstat_d;
      gen_q   <= gen_d;
    end
  end

  assign irq = |(gstat_q & gen_q);

  // Read path
  logic [31:0] rd_data_d;
  logic        rd_valid_q;
  logic [31:0] rd_data_q;

  always_comb begin
    rd_data_d = '0;
    if (rd) begin
      if (pin_hit)                          rd_data_d = pin_word[pin_idx];
      else if (req_addr == GRP_STAT_ADDR)   rd_data_d = 32'(gstat_q);
      else if (req_addr == GRP_EN_ADDR)     rd_data_d = 32'(gen_q);
      else if (req_addr == PIN_CNT_ADDR)    rd_data_d = {16'b0, 16'(NUM_PINS)};
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  AST_GSTAT_W1C: assert property (@(posedge clk) disable iff (!rst_i)
    $past(stat_wr) |-> ((gstat_q & $past(req_wdata[NUM_GROUPS-1:0] & ~grp_any)) == '0)); // R9
endmodule

// File: tb/tb_gpio_pinword_ctrl.sv
module tb_gpio_pinword_ctrl;
  localparam int NP = 8;
  localparam int GS = 3;
  localparam int NG = 3;
  localparam int DB = 16;
  localparam int BH = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [12:0]   req_addr;
  logic [31:0]   req_wdata;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic          irq;

  gpio_pinword_ctrl #(.NUM_PINS(NP), .GROUP_SIZE(GS), .DEB_CYCLES(DB), .BLINK_HALF(BH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";
  bit cmp_on = 0;

  // Behavioural reference
  int m_s1[NP], m_s2[NP], m_lvl[NP], m_cnt[NP];
  int m_deb[NP], m_ts[NP], m_out[NP], m_blk[NP], m_ren[NP], m_rfl[NP], m_fen[NP], m_ffl[NP];
  int m_gstat, m_gen, m_bcnt, m_phase, m_rs0, m_rs1;
  bit m_rdv;
  logic [31:0] m_rd;

  function automatic logic [31:0] m_word(int p);
    return 32'((m_ffl[p] << 8) | (m_fen[p] << 7) | (m_rfl[p] << 6) | (m_ren[p] << 5) |
               (m_blk[p] << 4) | (m_out[p] << 3) | (m_ts[p] << 2) | (m_deb[p] << 1) | m_lvl[p]);
  endfunction

  task automatic model_step();
    int a, wd, any, clr, nl, rise, fall, pw;
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_lvl[p] = 0; m_cnt[p] = 0; m_deb[p] = 0; m_ts[p] = 1;
        m_out[p] = 0; m_blk[p] = 0; m_ren[p] = 0; m_rfl[p] = 0; m_fen[p] = 0; m_ffl[p] = 0;
      end
      m_gstat = 0; m_gen = 0; m_bcnt = 0; m_phase = 0; m_rdv = 0; m_rd = 0;
      m_rs0 = 0; m_rs1 = 0;
      return;
    end
    if (m_rs1 != 0) begin
      a  = int'(req_addr);
      wd = int'(req_wdata);
      m_rdv = req_valid && !req_write;
      m_rd  = 0;
      if (m_rdv) begin
        if (a >= 4096 && a < 4096 + 4 * NP && a % 4 == 0) m_rd = m_word((a - 4096) / 4);
        else if (a == 0) m_rd = 32'(m_gstat);
        else if (a == 4) m_rd = 32'(m_gen);
        else if (a == 8) m_rd = 32'(NP);
      end
      any = 0;
      for (int p = 0; p < NP; p++) if (m_rfl[p] != 0 || m_ffl[p] != 0) any |= (1 << (p / GS));
      clr = (req_valid && req_write && a == 0) ? (wd & ((1 << NG) - 1)) : 0;
      m_gstat = (m_gstat & ~clr) | any;
      if (req_valid && req_write && a == 4) m_gen = wd & ((1 << NG) - 1);
      for (int p = 0; p < NP; p++) begin
        pw = (req_valid && req_write && a == 4096 + 4 * p) ? 1 : 0;
        nl = m_lvl[p];
        if (m_deb[p] == 0) begin
          nl = m_s2[p]; m_cnt[p] = 0;
        end else if (m_s2[p] == m_lvl[p]) begin
          m_cnt[p] = 0;
        end else if (m_cnt[p] == DB - 1) begin
          nl = m_s2[p]; m_cnt[p] = 0;
        end else begin
          m_cnt[p]++;
        end
        rise = (m_lvl[p] == 0 && nl == 1) ? 1 : 0;
        fall = (m_lvl[p] == 1 && nl == 0) ? 1 : 0;
        m_rfl[p] = ((m_rfl[p] != 0 && !(pw != 0 && wd[6])) || (rise != 0 && m_ren[p] != 0 && m_ts[p] != 0)) ? 1 : 0;
        m_ffl[p] = ((m_ffl[p] != 0 && !(pw != 0 && wd[8])) || (fall != 0 && m_fen[p] != 0 && m_ts[p] != 0)) ? 1 : 0;
        if (pw != 0) begin
          m_deb[p] = wd[1]; m_ts[p] = wd[2]; m_out[p] = wd[3];
          m_blk[p] = wd[4]; m_ren[p] = wd[5]; m_fen[p] = wd[7];
        end
        m_lvl[p] = nl;
        m_s2[p] = m_s1[p];
        m_s1[p] = int'(pin_in[p]);
      end
      if (m_bcnt == BH - 1) begin m_bcnt = 0; m_phase ^= 1; end
      else m_bcnt++;
    end
    m_rs1 = m_rs0;
    m_rs0 = 1;
  endtask

  always @(posedge clk) model_step();

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [NP-1:0] e_oe, e_out;
      for (int p = 0; p < NP; p++) begin
        e_oe[p]  = (m_ts[p] == 0);
        e_out[p] = (m_out[p] != 0) && (m_blk[p] == 0 || m_phase != 0);
      end
      chk({cur_tag, " rd_valid (R1)"}, 32'(rd_valid), 32'(m_rdv));
      chk({cur_tag, " rd_data"}, rd_data, m_rd);
      chk("R8 pin_oe", 32'(pin_oe), 32'(e_oe));
      chk("R8 pin_out", 32'(pin_out), 32'(e_out));
      chk("R10 irq", 32'(irq), 32'((m_gstat & m_gen) != 0));
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 13'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_read(int a, string tag);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_write = 0; req_addr = 13'(a);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_pin(int p, logic v);
    @(negedge clk);
    pin_in[p] = v;
  endtask

  initial begin
    int changes;
    logic prev;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; pin_in = '0;
    wait_cyc(3);
    cmp_on = 1;
    @(negedge clk); rst_n = 1;
    wait_cyc(3);

    // R2: reset state
    chk("R2 irq after reset", 32'(irq), 0);
    chk("R2 pin_oe after reset", 32'(pin_oe), 0);
    bus_read(32'h1000, "R2");      chk("R2 pin0 word", rd_data, 32'h4);
    bus_read(32'h101C, "R2");      chk("R2 pin7 word", rd_data, 32'h4);
    // R3
    bus_read(8, "R3");             chk("R3 pin count", rd_data, 32'd8);
    bus_write(8, 32'hFFFF);
    bus_read(8, "R3");             chk("R3 count after write", rd_data, 32'd8);

    // R4: level bit after synchroniser
    drive_pin(0, 1'b1);
    wait_cyc(5);
    bus_read(32'h1000, "R4");      chk("R4 level bit", rd_data, 32'h5);

    // Arm all pins as inputs with both edges enabled
    for (int p = 0; p < NP; p++) bus_write(32'h1000 + 4 * p, 32'hA4);

    // R6 falling edge on pin 0
    drive_pin(0, 1'b0);
    wait_cyc(5);
    bus_read(32'h1000, "R6");      chk("R6 fall flag", rd_data, 32'h1A4);
    bus_read(0, "R9");             chk("R9 group0 status", rd_data, 32'h1);
    chk("R10 irq masked", 32'(irq), 0);
    bus_write(4, 32'h7);
    chk("R10 irq enabled", 32'(irq), 1);
    bus_read(4, "R10");            chk("R10 enable readback", rd_data, 32'h7);

    // R7 write-back clears
    bus_write(32'h1000, 32'h1A4);
    bus_read(32'h1000, "R7");      chk("R7 flag cleared", rd_data, 32'hA4);
    bus_write(0, 32'h1);
    bus_read(0, "R9");             chk("R9 status cleared", rd_data, 32'h0);
    chk("R10 irq low", 32'(irq), 0);

    // R9 group 2 covers pins 6..7
    drive_pin(7, 1'b1);
    wait_cyc(5);
    bus_read(0, "R9");             chk("R9 group2 from pin7", rd_data, 32'h4);
    bus_write(32'h101C, 32'hE4);
    bus_write(0, 32'h4);
    bus_read(0, "R9");             chk("R9 group2 cleared", rd_data, 32'h0);

    // R9 status re-sets while flag held; R7 writing 0 keeps flag
    drive_pin(4, 1'b1);
    wait_cyc(5);
    bus_write(0, 32'h2);
    bus_read(0, "R9");             chk("R9 status held by flag", rd_data, 32'h2);
    bus_write(32'h1010, 32'hA4);
    bus_read(32'h1010, "R7");      chk("R7 zero keeps flag", rd_data, 32'hE5);
    bus_write(32'h1010, 32'hE4);
    bus_write(0, 32'h2);

    // R6 ignored while output-enabled
    bus_write(32'h1014, 32'hA0);
    drive_pin(5, 1'b1);
    wait_cyc(5);
    bus_read(32'h1014, "R6");      chk("R6 no flag when driven", rd_data, 32'hA1);

    // R5 debounce on pin 3
    bus_write(32'h100C, 32'hA6);
    drive_pin(3, 1'b1);
    wait_cyc(5);
    drive_pin(3, 1'b0);
    wait_cyc(6);
    bus_read(32'h100C, "R5");      chk("R5 glitch rejected", rd_data, 32'hA6);
    drive_pin(3, 1'b1);
    wait_cyc(30);
    bus_read(32'h100C, "R5");      chk("R5 steady accepted", rd_data, 32'hE7);
    bus_write(32'h100C, 32'hE6);
    bus_write(0, 32'h7);

    // R7 edge coincident with clear: flag stays
    @(negedge clk); pin_in[6] = 1'b1;
    @(negedge clk);
    bus_write(32'h1018, 32'hE4);
    bus_read(32'h1018, "R7");      chk("R7 edge beats clear", rd_data, 32'hE5);

    // R8 output drive and blink
    bus_write(32'h1004, 32'h08);
    chk("R8 oe pin1", 32'(pin_oe[1]), 1);
    chk("R8 out pin1", 32'(pin_out[1]), 1);
    bus_write(32'h1008, 32'h18);
    changes = 0;
    prev = pin_out[2];
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (pin_out[2] != prev) changes++;
      prev = pin_out[2];
    end
    chk("R8 blink toggles", 32'(changes), 32'd4);
    bus_write(32'h1008, 32'h10);
    wait_cyc(12);
    chk("R8 blink gated by out bit", 32'(pin_out[2]), 0);

    // R11 unmapped and out-of-range
    bus_write(32'h1020, 32'h1FF);
    bus_read(32'h1020, "R11");     chk("R11 pin8 reads 0", rd_data, 32'h0);
    bus_write(32'h1002, 32'h08);
    bus_read(32'h1000, "R11");     chk("R11 unaligned ignored", rd_data, 32'hA4);
    bus_write(32'h10, 32'hFF);
    bus_read(32'h10, "R11");       chk("R11 unmapped reads 0", rd_data, 32'h0);
    bus_read(4, "R11");            chk("R11 enable untouched", rd_data, 32'h7);

    wait_cyc(4);
    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule